// File: doc/BRIEF.md
# Dual-Port JTAG Bridge Controller

This block joins a host register bus to two separate IEEE 1149.1 test ports, a primary port and a secondary port. Out of reset it acts as a transparent link: whatever a backplane tester drives on the primary port's clock, mode-select, data-in and reset pins is forwarded straight onto the secondary chain, and that chain's data-out is returned on the primary data-out. The register interface has no effect on either port in this state.

One host write to the mode register converts the block into two independent scan masters, one per port. Each master holds a data word, a mode-select pattern and a length (1 to 32 bits) written by the host, and a start command shifts them out LSB first. The test data returned during the shift is captured and can be read back. Both masters can run at the same time. The test clock is derived from the system clock by a programmable half-period divider. A request to go back to transparent mode is held until both masters are idle.

Top module: `jtag_bridge`

## Requirements
- R1: After a synchronous reset the block is in pass-through mode (mode register bit 0 reads 0), the primary drive enable is low, both master clocks are low, both master reset outputs are high and both busy bits are 0.
- R2: In pass-through mode sec_tck, sec_tms, sec_tdi and sec_trst_n equal pri_tck_in, pri_tms_in, pri_tdi_in and pri_trst_n_in, and pri_tdo_out equals sec_tdo, combinationally with no register on the path.
- R3: In pass-through mode a host start or test-reset command is ignored: no master becomes busy, and the secondary pins keep following the primary inputs.
- R4: Register map (byte-free word addresses on host_addr): 0 = mode (bit 0: 1 = master), 1 = clock half-period; port 0 (primary) at 4..6 and port 1 (secondary) at 8..10, with offset 0 = data (write: TDI word, read: captured TDO word), offset 1 = TMS pattern, offset 2 = control (write: bits 4:0 length minus one, bit 8 start, bit 9 test reset; read: bits 4:0 length minus one, bit 16 busy). Reads return data one cycle after the address is presented. Writing 1 to the mode register enters master mode at the next clock edge and raises pri_drive.
- R5: A start in master mode produces exactly length-minus-one plus 1 test-clock pulses on that port; TDI and TMS carry bit i of the data word and pattern (LSB first) at the i-th rising test-clock edge, and change only while the test clock is low.
- R6: The TDO level present at the i-th rising test-clock edge is stored in bit i of the capture word; capture bits at or above the length read as 0.
- R7: Shifts on the two ports run concurrently and each port's results match what it would produce alone.
- R8: Each test-clock phase (high or low) lasts the half-period register value in system cycles; a value of 0 is treated as 1.
- R9: Busy reads 1 from the cycle after the start write and clears on the edge where the test clock falls after the last bit, 2 x length x half-period cycles after the start edge; the test clock stays low while idle.
- R10: While a port is busy, host writes to that port's data, pattern and control registers are ignored, including a second start.
- R11: A test-reset command in master mode drives that port's reset output low for exactly two half-periods (one full test-clock period), with busy set for the same time.
- R12: Writing 0 to the mode register while either master is busy leaves master mode in force until both are idle; the block then returns to pass-through with both master clocks low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register word address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| pri_tck_in | input | 1 | Primary test clock from backplane |
| pri_tms_in | input | 1 | Primary mode select from backplane |
| pri_tdi_in | input | 1 | Primary data in from backplane |
| pri_trst_n_in | input | 1 | Primary test reset from backplane, active low |
| pri_tdo_out | output | 1 | Primary data out to backplane (pass-through) |
| pri_tdo_in | input | 1 | Primary chain data out seen by the master |
| pri_tck_out | output | 1 | Primary master test clock |
| pri_tms_out | output | 1 | Primary master mode select |
| pri_tdi_out | output | 1 | Primary master data |
| pri_trst_n_out | output | 1 | Primary master test reset, active low |
| pri_drive | output | 1 | High when the primary master outputs should drive the pins |
| sec_tck | output | 1 | Secondary chain test clock |
| sec_tms | output | 1 | Secondary chain mode select |
| sec_tdi | output | 1 | Secondary chain data |
| sec_trst_n | output | 1 | Secondary chain test reset, active low |
| sec_tdo | input | 1 | Secondary chain data out |

## Verification
Pass-through routing has no register, so it is checked one nanosecond after the primary inputs change, in the same cycle. Master results are timed from the start-write edge: with half-period d the i-th rising test-clock edge comes (2i+1)·d cycles later and busy falls after 2·L·d cycles, so the busy check samples the status read the cycle before and the cycle after that edge, allowing for the one-cycle read latency. Reset width is counted in negedge samples of the reset pin, and everything else is compared once the status register reports idle.

// File: rtl/jtag_bridge_pkg.sv
package jtag_bridge_pkg;
  localparam int ADDR_W         = 4;
  localparam int NPORT          = 2;
  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_TMS  = 2'd1;
  localparam logic [1:0] OFS_CTRL = 2'd2;
  localparam int CTRL_START_BIT = 8;
  localparam int CTRL_TRST_BIT  = 9;
  localparam int STAT_BUSY_BIT  = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_RST
  } tap_state_e;
endpackage

// File: rtl/jtag_tap_master.sv
module jtag_tap_master
  import jtag_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W),
  localparam int CNT_W = DIV_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              start_i,
  input  logic              trst_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] tdi_i,
  input  logic [DATA_W-1:0] tms_i,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              trst_n_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] cap_o
);
  tap_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  idx_q, len_q;
  logic [DATA_W-1:0] tdi_w_q, tms_w_q, cap_q;
  logic              tck_q, tms_q, tdi_q, trst_n_q, busy_q;
  logic [LEN_W-1:0]  idx_nx;
  logic [CNT_W-1:0]  half_end, full_end;

  assign idx_nx   = idx_q + 1'b1;
  assign half_end = CNT_W'(half_i) - 1'b1;
  assign full_end = {half_i, 1'b0} - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      idx_q    <= '0;
      len_q    <= '0;
      tdi_w_q  <= '0;
      tms_w_q  <= '0;
      cap_q    <= '0;
      tck_q    <= 1'b0;
      tms_q    <= 1'b0;
      tdi_q    <= 1'b0;
      trst_n_q <= 1'b1;
      busy_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_i) begin
            len_q   <= len_i;
            tdi_w_q <= tdi_i;
            tms_w_q <= tms_i;
            tdi_q   <= tdi_i[0];
            tms_q   <= tms_i[0];
            idx_q   <= '0;
            cap_q   <= '0;
            busy_q  <= 1'b1;
            state_q <= ST_LOW;
          end else if (trst_i) begin
            trst_n_q <= 1'b0;
            busy_q   <= 1'b1;
            state_q  <= ST_RST;
          end
        end
        ST_LOW: begin
          if (cnt_q == half_end) begin
            cnt_q        <= '0;
            tck_q        <= 1'b1;
            cap_q[idx_q] <= tdo_i;
            state_q      <= ST_HIGH;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_q == half_end) begin
            cnt_q <= '0;
            tck_q <= 1'b0;
            if (idx_q == len_q) begin
              busy_q  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              idx_q   <= idx_nx;
              tdi_q   <= tdi_w_q[idx_nx];
              tms_q   <= tms_w_q[idx_nx];
              state_q <= ST_LOW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RST: begin
          if (cnt_q == full_end) begin
            cnt_q    <= '0;
            trst_n_q <= 1'b1;
            busy_q   <= 1'b0;
            state_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tck_o    = tck_q;
  assign tms_o    = tms_q;
  assign tdi_o    = tdi_q;
  assign trst_n_o = trst_n_q;
  assign busy_o   = busy_q;
  assign cap_o    = cap_q;

  // R5: data and pattern never move while the test clock is high
  p_tdi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    tck_q |-> ($stable(tdi_q) && $stable(tms_q)));
  // R5: busy only ever rises because of a command
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_i || trst_i));
  // R9: idle master keeps its test clock low
  p_tck_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !tck_q);
  // R11: reset pulse is always covered by busy
  p_trst_busy_r11: assert property (@(posedge clk) disable iff (rst)
    !trst_n_q |-> busy_q);
  // R10: a running transfer keeps its length
  p_len_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(len_q));
endmodule

// File: rtl/jtag_bridge_regs.sv
module jtag_bridge_regs
  import jtag_bridge_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1,
  localparam int LEN_W    = $clog2(DATA_W)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_we,
  input  logic [ADDR_W-1:0]            host_addr,
  input  logic [DATA_W-1:0]            host_wdata,
  output logic [DATA_W-1:0]            host_rdata,
  input  logic [NPORT-1:0]             busy_i,
  input  logic [NPORT-1:0][DATA_W-1:0] cap_i,
  output logic                         master_o,
  output logic [DIV_W-1:0]             half_o,
  output logic [NPORT-1:0]             start_o,
  output logic [NPORT-1:0]             trst_o,
  output logic [NPORT-1:0][LEN_W-1:0]  len_o,
  output logic [NPORT-1:0][DATA_W-1:0] tdi_o,
  output logic [NPORT-1:0][DATA_W-1:0] tms_o
);
  logic             mode_q, req_q, req_nx, busy_any;
  logic [DIV_W-1:0] div_q;
  logic [DATA_W-1:0] rd_nx;
  logic [1:0]       ofs;

  assign busy_any = |busy_i;
  assign ofs      = host_addr[1:0];
  assign req_nx   = (host_we && host_addr == ADDR_W'(0)) ? host_wdata[0] : req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      req_q  <= 1'b0;
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      req_q <= req_nx;
      if (req_nx)
        mode_q <= 1'b1;
      else if (!busy_any)
        mode_q <= 1'b0;
      if (host_we && host_addr == ADDR_W'(1))
        div_q <= host_wdata[DIV_W-1:0];
    end
  end

  assign master_o = mode_q;
  assign half_o   = (div_q == '0) ? DIV_W'(1) : div_q;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [1:0] PSEL = 2'(p + 1);
    logic              hit, ctrl_wr;
    logic [DATA_W-1:0] tdi_q, tms_q;
    logic [LEN_W-1:0]  len_q;

    assign hit     = host_we && host_addr[ADDR_W-1:2] == PSEL && !busy_i[p];
    assign ctrl_wr = hit && ofs == OFS_CTRL;

    always_ff @(posedge clk) begin
      if (rst) begin
        tdi_q <= '0;
        tms_q <= '0;
        len_q <= '0;
      end else if (hit) begin
        case (ofs)
          OFS_DATA: tdi_q <= host_wdata;
          OFS_TMS:  tms_q <= host_wdata;
          OFS_CTRL: len_q <= host_wdata[LEN_W-1:0];
          default:  ;
        endcase
      end
    end

    assign start_o[p] = ctrl_wr && host_wdata[CTRL_START_BIT] && mode_q && req_nx;
    assign trst_o[p]  = ctrl_wr && host_wdata[CTRL_TRST_BIT] && mode_q && req_nx;
    assign len_o[p]   = ctrl_wr ? host_wdata[LEN_W-1:0] : len_q;
    assign tdi_o[p]   = tdi_q;
    assign tms_o[p]   = tms_q;
  end

  always_comb begin
    rd_nx = '0;
    if (host_addr[ADDR_W-1:2] == 2'd0) begin
      if (ofs == 2'd0)      rd_nx[0]       = mode_q;
      else if (ofs == 2'd1) rd_nx[DIV_W-1:0] = div_q;
    end
    for (int p = 0; p < NPORT; p++) begin
      if (host_addr[ADDR_W-1:2] == 2'(p + 1)) begin
        case (ofs)
          OFS_DATA: rd_nx = cap_i[p];
          OFS_TMS:  rd_nx = tms_o[p];
          OFS_CTRL: begin
            rd_nx[LEN_W-1:0]     = len_o[p];
            rd_nx[STAT_BUSY_BIT] = busy_i[p];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_nx;
  end

  // R4: a mode write of 1 takes effect at the next edge
  p_mode_enter_r4: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == ADDR_W'(0) && host_wdata[0]) |=> mode_q);
  // R12: leaving master mode only happens with both masters idle
  p_mode_leave_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_q) |-> !$past(busy_any));
  // R3: no master is commanded in pass-through mode
  p_no_cmd_pass_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> $stable(busy_i) || $fell(|busy_i) || busy_i == '0);
endmodule

// File: rtl/jtag_bridge.sv
module jtag_bridge
  import jtag_bridge_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              pri_tck_in,
  input  logic              pri_tms_in,
  input  logic              pri_tdi_in,
  input  logic              pri_trst_n_in,
  output logic              pri_tdo_out,
  input  logic              pri_tdo_in,
  output logic              pri_tck_out,
  output logic              pri_tms_out,
  output logic              pri_tdi_out,
  output logic              pri_trst_n_out,
  output logic              pri_drive,
  output logic              sec_tck,
  output logic              sec_tms,
  output logic              sec_tdi,
  output logic              sec_trst_n,
  input  logic              sec_tdo
);
  localparam int LEN_W = $clog2(DATA_W);

  logic                         master;
  logic [DIV_W-1:0]             half;
  logic [NPORT-1:0]             start, trst, busy;
  logic [NPORT-1:0]             m_tck, m_tms, m_tdi, m_trst_n, tdo_vec;
  logic [NPORT-1:0][LEN_W-1:0]  len;
  logic [NPORT-1:0][DATA_W-1:0] tdi_w, tms_w, cap;

  assign tdo_vec = {sec_tdo, pri_tdo_in};

  jtag_bridge_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy_i    (busy),
    .cap_i     (cap),
    .master_o  (master),
    .half_o    (half),
    .start_o   (start),
    .trst_o    (trst),
    .len_o     (len),
    .tdi_o     (tdi_w),
    .tms_o     (tms_w)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_master
    jtag_tap_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_master (
      .clk     (clk),
      .rst     (rst),
      .half_i  (half),
      .start_i (start[p]),
      .trst_i  (trst[p]),
      .len_i   (len[p]),
      .tdi_i   (tdi_w[p]),
      .tms_i   (tms_w[p]),
      .tdo_i   (tdo_vec[p]),
      .tck_o   (m_tck[p]),
      .tms_o   (m_tms[p]),
      .tdi_o   (m_tdi[p]),
      .trst_n_o(m_trst_n[p]),
      .busy_o  (busy[p]),
      .cap_o   (cap[p])
    );
  end

  assign pri_tck_out    = m_tck[0];
  assign pri_tms_out    = m_tms[0];
  assign pri_tdi_out    = m_tdi[0];
  assign pri_trst_n_out = m_trst_n[0];
  assign pri_drive      = master;
  assign pri_tdo_out    = master ? 1'b0 : sec_tdo;

  assign sec_tck    = master ? m_tck[1]    : pri_tck_in;
  assign sec_tms    = master ? m_tms[1]    : pri_tms_in;
  assign sec_tdi    = master ? m_tdi[1]    : pri_tdi_in;
  assign sec_trst_n = master ? m_trst_n[1] : pri_trst_n_in;

  // R12: leaving master mode leaves both master clocks low
  p_pass_tck_low_r12: assert property (@(posedge clk) disable iff (rst)
    !master |-> (m_tck == '0));
endmodule

// File: tb/jtag_bridge_bench.sv
module jtag_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic pri_tck_in = 0, pri_tms_in = 0, pri_tdi_in = 0, pri_trst_n_in = 1;
  logic pri_tdo_out, pri_tdo_in, pri_tck_out, pri_tms_out, pri_tdi_out, pri_trst_n_out, pri_drive;
  logic sec_tck, sec_tms, sec_tdi, sec_trst_n, sec_tdo;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  jtag_bridge u_jtag_bridge (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pri_tck_in(pri_tck_in), .pri_tms_in(pri_tms_in), .pri_tdi_in(pri_tdi_in),
    .pri_trst_n_in(pri_trst_n_in), .pri_tdo_out(pri_tdo_out), .pri_tdo_in(pri_tdo_in),
    .pri_tck_out(pri_tck_out), .pri_tms_out(pri_tms_out), .pri_tdi_out(pri_tdi_out),
    .pri_trst_n_out(pri_trst_n_out), .pri_drive(pri_drive),
    .sec_tck(sec_tck), .sec_tms(sec_tms), .sec_tdi(sec_tdi), .sec_trst_n(sec_trst_n),
    .sec_tdo(sec_tdo)
  );

  // target chains: 4-bit on the primary master, 8-bit on the secondary
  logic [3:0]  psr = 4'hB;
  logic [7:0]  ssr = 8'h6C;
  logic [31:0] hist_tdi [2];
  logic [31:0] hist_tms [2];
  int          pulses [2];
  int          hi_cyc [2];
  assign pri_tdo_in = psr[0];
  assign sec_tdo    = ssr[0];

  initial begin
    for (int k = 0; k < 2; k++) begin
      hist_tdi[k] = '0; hist_tms[k] = '0; pulses[k] = 0; hi_cyc[k] = 0;
    end
  end

  always @(posedge pri_tck_out) begin
    hist_tdi[0] = {pri_tdi_out, hist_tdi[0][31:1]};
    hist_tms[0] = {pri_tms_out, hist_tms[0][31:1]};
    pulses[0]   = pulses[0] + 1;
    psr         = {pri_tdi_out, psr[3:1]};
  end
  always @(posedge sec_tck) begin
    hist_tdi[1] = {sec_tdi, hist_tdi[1][31:1]};
    hist_tms[1] = {sec_tms, hist_tms[1][31:1]};
    pulses[1]   = pulses[1] + 1;
    ssr         = {sec_tdi, ssr[7:1]};
  end
  always @(negedge clk) begin
    if (pri_tck_out) hi_cyc[0] = hi_cyc[0] + 1;
    if (sec_tck)     hi_cyc[1] = hi_cyc[1] + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_idle(input int port);
    logic [31:0] st;
    st = 32'h1_0000;
    for (int k = 0; k < 4000 && st[16]; k++)
      host_read(4'(4 * (port + 1) + 2), st);
  endtask

  function automatic logic [31:0] lmask(input int len);
    logic [63:0] m;
    m = (64'd1 << len) - 64'd1;
    return m[31:0];
  endfunction

  function automatic logic [31:0] exp_cap(input int port, input int len, input logic [31:0] tdi);
    logic [63:0] comb;
    comb = (port == 0) ? (({32'd0, tdi} << 4) | 64'(psr)) : (({32'd0, tdi} << 8) | 64'(ssr));
    return comb[31:0] & lmask(len);
  endfunction

  // vector: port[77], len-1[76:72], half-period[71:64], tdi[63:32], tms[31:0]
  localparam int NVEC = 6;
  localparam logic [77:0] VEC [NVEC] = '{
    {1'b1, 5'd7,  8'd1, 32'h0000_00A5, 32'h0000_0003},
    {1'b0, 5'd0,  8'd1, 32'h0000_0001, 32'h0000_0001},
    {1'b1, 5'd31, 8'd1, 32'hDEAD_BEEF, 32'h8000_0001},
    {1'b0, 5'd12, 8'd3, 32'h0000_1C3A, 32'h0000_1000},
    {1'b1, 5'd4,  8'd0, 32'h0000_0015, 32'h0000_0010},
    {1'b0, 5'd19, 8'd2, 32'h000A_5F0F, 32'h0008_0001}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd, ec;
    int lows;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    host_read(4'd0, rd);
    check("R1 mode", rd, 32'd0);
    check("R1 drive", {31'd0, pri_drive}, 32'd0);
    check("R1 tck", {31'd0, pri_tck_out}, 32'd0);
    check("R1 trst", {31'd0, pri_trst_n_out}, 32'd1);
    host_read(4'd10, rd);
    check("R1 busy", {31'd0, rd[16]}, 32'd0);

    // R2: transparent routing, all input patterns
    for (int pat = 0; pat < 16; pat++) begin
      @(negedge clk);
      {pri_tck_in, pri_tms_in, pri_tdi_in, pri_trst_n_in} = 4'(pat);
      #1;
      check("R2 route", {28'd0, sec_tck, sec_tms, sec_tdi, sec_trst_n}, 32'(pat));
      check("R2 tdo", {31'd0, pri_tdo_out}, {31'd0, ssr[0]});
    end

    // R3: commands ignored in pass-through
    @(negedge clk);
    {pri_tck_in, pri_tms_in, pri_tdi_in, pri_trst_n_in} = 4'b0011;
    host_write(4'd10, 32'h0000_0107);
    host_write(4'd6, 32'h0000_0200);
    host_read(4'd10, rd);
    check("R3 busy", {31'd0, rd[16]}, 32'd0);
    check("R3 route", {28'd0, sec_tck, sec_tms, sec_tdi, sec_trst_n}, 32'b0011);
    check("R3 pri trst", {31'd0, pri_trst_n_out}, 32'd1);

    // R4: enter master mode
    host_write(4'd0, 32'd1);
    pri_tck_in = 1'b1;
    host_read(4'd0, rd);
    check("R4 mode", rd, 32'd1);
    check("R4 drive", {31'd0, pri_drive}, 32'd1);
    check("R4 sec tck", {31'd0, sec_tck}, 32'd0);

    // R5 R6 R8: table of single-port shifts
    for (int v = 0; v < NVEC; v++) begin
      int port, len, half, p0, h0;
      logic [31:0] tdi, tms;
      port = int'(VEC[v][77]);
      len  = int'(VEC[v][76:72]) + 1;
      half = (VEC[v][71:64] == 8'd0) ? 1 : int'(VEC[v][71:64]);
      tdi  = VEC[v][63:32];
      tms  = VEC[v][31:0];
      ec   = exp_cap(port, len, tdi);
      p0 = pulses[port]; h0 = hi_cyc[port];
      host_write(4'd1, {24'd0, VEC[v][71:64]});
      host_write(4'(4 * (port + 1)), tdi);
      host_write(4'(4 * (port + 1) + 1), tms);
      host_write(4'(4 * (port + 1) + 2), {23'd0, 1'b1, 3'd0, VEC[v][76:72]});
      wait_idle(port);
      host_read(4'(4 * (port + 1)), rd);
      check("R6 capture", rd, ec);
      check("R5 pulses", 32'(pulses[port] - p0), 32'(len));
      check("R5 tdi", hist_tdi[port] >> (32 - len), tdi & lmask(len));
      check("R5 tms", hist_tms[port] >> (32 - len), tms & lmask(len));
      check("R8 high time", 32'(hi_cyc[port] - h0), 32'(len * half));
    end

    // R7: both ports concurrently
    begin
      logic [31:0] e0, e1;
      int a0, a1;
      host_write(4'd1, 32'd2);
      e0 = exp_cap(0, 10, 32'h2B5);
      e1 = exp_cap(1, 16, 32'hC3A9);
      a0 = pulses[0]; a1 = pulses[1];
      host_write(4'd4, 32'h2B5);
      host_write(4'd8, 32'hC3A9);
      host_write(4'd6, 32'h109);
      host_write(4'd10, 32'h10F);
      host_read(4'd6, rd);
      check("R7 overlap", {31'd0, rd[16]}, 32'd1);
      wait_idle(0);
      wait_idle(1);
      host_read(4'd4, rd);
      check("R7 cap pri", rd, e0);
      host_read(4'd8, rd);
      check("R7 cap sec", rd, e1);
      check("R7 pulses pri", 32'(pulses[0] - a0), 32'd10);
      check("R7 pulses sec", 32'(pulses[1] - a1), 32'd16);
    end

    // R9: busy timing, L=3, half=1 -> clears 6 edges after start
    host_write(4'd1, 32'd1);
    host_write(4'd10, 32'h102);
    host_addr = 4'd10;
    repeat (6) @(negedge clk);
    check("R9 busy before", {31'd0, host_rdata[16]}, 32'd1);
    @(negedge clk);
    check("R9 busy after", {31'd0, host_rdata[16]}, 32'd0);
    check("R9 tck idle", {31'd0, sec_tck}, 32'd0);

    // R10: second start during a transfer is ignored
    begin
      int b0;
      b0 = pulses[1];
      host_write(4'd10, 32'h10F);
      host_write(4'd10, 32'h102);
      wait_idle(1);
      check("R10 pulses", 32'(pulses[1] - b0), 32'd16);
      host_read(4'd10, rd);
      check("R10 len kept", {27'd0, rd[4:0]}, 32'd15);
    end

    // R11: test reset pulse with half=2 lasts 4 cycles
    host_write(4'd1, 32'd2);
    lows = 0;
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'd10; host_wdata = 32'h200;
    @(negedge clk);
    host_we = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (!sec_trst_n) lows++;
      @(negedge clk);
    end
    check("R11 low cycles", 32'(lows), 32'd4);
    check("R11 released", {31'd0, sec_trst_n}, 32'd1);

    // R12: deferred return to pass-through
    host_write(4'd1, 32'd1);
    host_write(4'd10, 32'h11F);
    host_write(4'd0, 32'd0);
    host_read(4'd0, rd);
    check("R12 held", rd, 32'd1);
    wait_idle(1);
    host_read(4'd0, rd);
    check("R12 released", rd, 32'd0);
    pri_tck_in = 1'b1;
    #1;
    check("R12 sec follows", {31'd0, sec_tck}, 32'd1);
    check("R12 pri tck low", {31'd0, pri_tck_out}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule